// File: doc/BRIEF.md
# Serial Controller Configuration Sequencer

This block sits behind the control address of a programmable serial controller and decides what each CPU write to that address means. Directly after any reset the first control write is taken as the mode word, which fixes the character format, parity, stop bits, and the choice between asynchronous and synchronous operation.

In synchronous operation the next one or two control writes are stored as sync characters. Every control write after that loads the command register. The latched mode fields, the sync characters and the command bits are driven straight out to the transmitter and receiver.

Setting the master-reset bit in a command word starts an internal reset. It clears the registers and sends the sequencer back to expecting a mode word. The same way back is taken after an external reset.

Top module: `cfg_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output register returns to zero. This covers the mode fields (so `char_bits` reads 5), the sync characters, the command word and both pulses. The sequencer then expects a mode word.
- R2: A write is accepted only when `bus_sel`, `bus_ctl` and `bus_wr` are all high at a rising edge. Any other write leaves every output unchanged.
- R3: The first accepted control write after any reset loads the mode register. If its bits[1:0] are not 00, the next control write is a command.
- R4: A command write with bit 6 set raises `soft_reset` for exactly the one cycle after the write. At that edge it clears the mode register, the sync characters and the command word. The next control write is then taken as a mode word, even one made in that same cycle.
- R5: Once the mode word is loaded, later control writes never change it until a reset.
- R6: Bits[1:0] = 00 select synchronous operation, and bit 7 then sets the sync-character count. When bit 7 is 1, one sync write loads `sync_chars[7:0]`. When bit 7 is 0, two sync writes load `sync_chars[7:0]` and then `sync_chars[15:8]`. Only after those writes are control writes taken as commands, and a sync write with bit 6 set causes no reset.
- R7: A command write stores its byte in `cmd_word` with bits 4 and 6 forced to zero. `tx_enable` follows bit 0 and `send_break` follows bit 3.
- R8: A command write with bit 4 set raises `err_clear` for the one cycle after the write only. If bit 6 is also set, `err_clear` and `soft_reset` are high in the same cycle.
- R9: The mode word decodes as follows:
  - `baud_sel` = bits[1:0], where 00 is synchronous, 01 is 1x, 10 is 16x and 11 is 64x.
  - `char_bits` = 5 + bits[3:2].
  - `parity_en` = bit 4 and `parity_even` = bit 5.
  - `stop_code` = bits[7:6].
  - `sync_single` = bit 7.
- R10: An external reset applied in the same cycle as an accepted control write wins, and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Chip select, active high |
| bus_ctl | input | 1 | 1 = control address, 0 = data address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_din | input | 8 | Write data |
| baud_sel | output | 2 | Baud factor / synchronous select |
| char_bits | output | 4 | Character length, 5 to 8 |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity selected |
| stop_code | output | 2 | Stop-bit code |
| sync_single | output | 1 | One sync character (synchronous mode) |
| sync_chars | output | 16 | Sync characters, first in low byte |
| cmd_word | output | 8 | Held command bits |
| tx_enable | output | 1 | Transmit enable |
| send_break | output | 1 | Send break |
| err_clear | output | 1 | One-cycle error-clear pulse |
| soft_reset | output | 1 | One-cycle internal reset pulse |

## Verification
Two functions can fall in the same cycle: an error-clear request and a master-reset request carried in one command byte. A command byte with both bit 4 and bit 6 set provokes this. It is judged correct when `err_clear` and `soft_reset` are high together for one cycle while the mode register and command word read zero. A second overlap comes from writing a new mode word in the very cycle `soft_reset` is high; the word must load. A third comes from holding `rst_n` low during an accepted write, and the write must vanish.

// File: rtl/cfg_seq_pkg.sv
// Package: shared phase type, mode layout and command bit positions for
// the configuration sequencer. Assumes an 8-bit control byte.
package cfg_seq_pkg;

    typedef enum logic [1:0] {
        PH_MODE = 2'd0,
        PH_SYNC = 2'd1,
        PH_CMD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [1:0] stop;
        logic       par_even;
        logic       par_en;
        logic [1:0] len;
        logic [1:0] baud;
    } mode_t;

    localparam int          BYTE_W         = 8;
    localparam logic [1:0]  BAUD_SYNC      = 2'b00;
    localparam int          MODE_SINGLE_BIT = 7;
    localparam int          CMD_TXEN_BIT   = 0;
    localparam int          CMD_BRK_BIT    = 3;
    localparam int          CMD_ERR_BIT    = 4;
    localparam int          CMD_SRST_BIT   = 6;
    localparam int          CHAR_BASE      = 5;

endpackage

// File: rtl/cfg_seq_fsm.sv
// Module: write-sequencing state machine. Qualifies bus writes to the
// control address and steers each one to the mode, sync or command
// destination according to the post-reset phase. Raises a one-cycle
// internal reset after a command carrying the master-reset bit.
// Assumes: synchronous active-low reset; one write per strobe cycle.
module cfg_seq_fsm
    import cfg_seq_pkg::*;
#(
    parameter int MAX_SYNC = 2,
    localparam int CNT_W   = (MAX_SYNC > 1) ? $clog2(MAX_SYNC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_ctl,
    input  logic             bus_wr,
    input  logic [BYTE_W-1:0] bus_din,
    input  logic             sync_single,
    output phase_e           phase,
    output logic             mode_ld,
    output logic             sync_ld,
    output logic [CNT_W-1:0] sync_idx,
    output logic             cmd_ld,
    output logic             clr_all,
    output logic             soft_reset
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             srst_q;
    logic             ctl_wr;
    logic [CNT_W-1:0] last_idx;

    // Purpose: qualify a control-address write and decode its destination.
    always_comb begin
        ctl_wr   = bus_sel && bus_ctl && bus_wr;
        mode_ld  = ctl_wr && (phase_q == PH_MODE);
        sync_ld  = ctl_wr && (phase_q == PH_SYNC);
        cmd_ld   = ctl_wr && (phase_q == PH_CMD);
        clr_all  = cmd_ld && bus_din[CMD_SRST_BIT];
        last_idx = sync_single ? CNT_W'(0) : CNT_W'(MAX_SYNC - 1);
    end

    // Purpose: advance the phase and sync counter on each control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_MODE;
            cnt_q   <= '0;
            srst_q  <= 1'b0;
        end else begin
            srst_q <= clr_all;
            unique case (phase_q)
                PH_MODE: begin
                    if (mode_ld) begin
                        cnt_q   <= '0;
                        phase_q <= (bus_din[1:0] == BAUD_SYNC) ? PH_SYNC : PH_CMD;
                    end
                end
                PH_SYNC: begin
                    if (sync_ld) begin
                        if (cnt_q == last_idx) begin
                            phase_q <= PH_CMD;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                PH_CMD: begin
                    if (clr_all) begin
                        phase_q <= PH_MODE;
                    end
                end
                default: phase_q <= PH_MODE;
            endcase
        end
    end

    assign phase      = phase_q;
    assign sync_idx   = cnt_q;
    assign soft_reset = srst_q;

    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> !soft_reset);                                   // R4
    AST_SRST_BACK_TO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |-> (phase == PH_MODE));                            // R4
    AST_SYNC_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SYNC) |-> (int'(sync_idx) < MAX_SYNC));           // R6
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase != phase_e'(2'd3));                                      // R3

endmodule

// File: rtl/cfg_mode_reg.sv
// Module: mode register. Captures the mode byte when the sequencer is in
// its mode phase; cleared by external or internal reset.
// Assumes: load and clear come from the sequencer, never together.
module cfg_mode_reg
    import cfg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld,
    input  logic [BYTE_W-1:0] din,
    output mode_t             mode_q
);

    // Purpose: hold the mode byte until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mode_q <= '0;
        end else if (ld) begin
            mode_q <= mode_t'(din);
        end
    end

endmodule

// File: rtl/cfg_sync_bank.sv
// Module: sync-character storage, one byte per slot, loaded in the order
// the sequencer counts sync writes. Cleared by any reset.
// Assumes: idx is below SLOTS whenever ld is high.
module cfg_sync_bank
    import cfg_seq_pkg::*;
#(
    parameter int SLOTS   = 2,
    localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    ld,
    input  logic [IDX_W-1:0]        idx,
    input  logic [BYTE_W-1:0]       din,
    output logic [SLOTS*BYTE_W-1:0] chars
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;

        // Purpose: capture this slot's sync byte when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                slot_q <= '0;
            end else if (ld && (int'(idx) == g)) begin
                slot_q <= din;
            end
        end

        assign chars[g*BYTE_W +: BYTE_W] = slot_q;
    end

endmodule

// File: rtl/cfg_cmd_reg.sv
// Module: command register. Holds the level command bits, drops the
// error-reset and master-reset bits, and turns the error-reset bit into
// a one-cycle pulse. An internal reset clears the held bits.
// Assumes: ld marks a command-phase control write.
module cfg_cmd_reg
    import cfg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              err_pulse
);

    localparam logic [BYTE_W-1:0] PULSE_MASK =
        (BYTE_W'(1) << CMD_ERR_BIT) | (BYTE_W'(1) << CMD_SRST_BIT);

    // Purpose: store held command bits with pulse bits masked off.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cmd_q <= '0;
        end else if (ld) begin
            cmd_q <= din & ~PULSE_MASK;
        end
    end

    // Purpose: one-cycle error-clear pulse per requesting command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= ld && din[CMD_ERR_BIT];
        end
    end

    AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(ld && din[CMD_ERR_BIT]));                  // R8
    AST_PULSE_BITS_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ld) |-> (cmd_q[CMD_ERR_BIT] == 1'b0));                   // R7

endmodule

// File: rtl/cfg_sequencer.sv
// Module: top of the configuration sequencer. Connects the write
// sequencer to the mode, sync and command registers and decodes the mode
// fields for the transmitter and receiver.
// Assumes: synchronous active-low reset; single clock domain.
module cfg_sequencer
    import cfg_seq_pkg::*;
#(
    parameter int MAX_SYNC  = 2,
    localparam int SYNC_W   = MAX_SYNC * BYTE_W,
    localparam int IDX_W    = (MAX_SYNC > 1) ? $clog2(MAX_SYNC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_ctl,
    input  logic              bus_wr,
    input  logic [7:0]        bus_din,
    output logic [1:0]        baud_sel,
    output logic [3:0]        char_bits,
    output logic              parity_en,
    output logic              parity_even,
    output logic [1:0]        stop_code,
    output logic              sync_single,
    output logic [SYNC_W-1:0] sync_chars,
    output logic [7:0]        cmd_word,
    output logic              tx_enable,
    output logic              send_break,
    output logic              err_clear,
    output logic              soft_reset
);

    phase_e           phase_w;
    logic             mode_ld;
    logic             sync_ld;
    logic             cmd_ld;
    logic             clr_all;
    logic [IDX_W-1:0] sync_idx;
    mode_t            mode_q;

    cfg_seq_fsm #(.MAX_SYNC(MAX_SYNC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_ctl    (bus_ctl),
        .bus_wr     (bus_wr),
        .bus_din    (bus_din),
        .sync_single(sync_single),
        .phase      (phase_w),
        .mode_ld    (mode_ld),
        .sync_ld    (sync_ld),
        .sync_idx   (sync_idx),
        .cmd_ld     (cmd_ld),
        .clr_all    (clr_all),
        .soft_reset (soft_reset)
    );

    cfg_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .ld    (mode_ld),
        .din   (bus_din),
        .mode_q(mode_q)
    );

    cfg_sync_bank #(.SLOTS(MAX_SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_all),
        .ld   (sync_ld),
        .idx  (sync_idx),
        .din  (bus_din),
        .chars(sync_chars)
    );

    cfg_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .ld       (cmd_ld),
        .din      (bus_din),
        .cmd_q    (cmd_word),
        .err_pulse(err_clear)
    );

    // Purpose: decode the latched mode byte into its output fields.
    always_comb begin
        baud_sel    = mode_q.baud;
        char_bits   = 4'(CHAR_BASE) + {2'b00, mode_q.len};
        parity_en   = mode_q.par_en;
        parity_even = mode_q.par_even;
        stop_code   = mode_q.stop;
        sync_single = mode_q.stop[MODE_SINGLE_BIT - 6];
        tx_enable   = cmd_word[CMD_TXEN_BIT];
        send_break  = cmd_word[CMD_BRK_BIT];
    end

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_w != PH_MODE) && !clr_all) |=> $stable(mode_q));       // R5
    AST_SRST_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |-> (mode_q == '0 && cmd_word == '0));              // R4
    AST_SYNC_SLOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_w == PH_CMD && !clr_all) |=> $stable(sync_chars));      // R6

endmodule

// File: tb/cfg_sequencer_test.sv
// Bench: vector table walked by one loop, then directed corner tests.
module cfg_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_ctl, bus_wr;
    logic [7:0]  bus_din;
    logic [1:0]  baud_sel;
    logic [3:0]  char_bits;
    logic        parity_en, parity_even;
    logic [1:0]  stop_code;
    logic        sync_single;
    logic [15:0] sync_chars;
    logic [7:0]  cmd_word;
    logic        tx_enable, send_break, err_clear, soft_reset;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfg_sequencer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_ctl(bus_ctl),
        .bus_wr(bus_wr), .bus_din(bus_din), .baud_sel(baud_sel),
        .char_bits(char_bits), .parity_en(parity_en),
        .parity_even(parity_even), .stop_code(stop_code),
        .sync_single(sync_single), .sync_chars(sync_chars),
        .cmd_word(cmd_word), .tx_enable(tx_enable), .send_break(send_break),
        .err_clear(err_clear), .soft_reset(soft_reset)
    );

    typedef struct packed {
        logic        rn;
        logic        sel;
        logic        ctl;
        logic        wr;
        logic [7:0]  din;
        logic [7:0]  em;
        logic [7:0]  ec;
        logic        ee;
        logic        es;
        logic [15:0] esy;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VT [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h00,1'b0,1'b0,16'h0000, 4'd1 },  // R1 idle
        '{1'b1,1'b0,1'b1,1'b1,8'h4E, 8'h00,8'h00,1'b0,1'b0,16'h0000, 4'd2 },  // R2 no select
        '{1'b1,1'b1,1'b0,1'b1,8'h4E, 8'h00,8'h00,1'b0,1'b0,16'h0000, 4'd2 },  // R2 data address
        '{1'b1,1'b1,1'b1,1'b1,8'hDE, 8'hDE,8'h00,1'b0,1'b0,16'h0000, 4'd3 },  // R3 mode async 16x
        '{1'b1,1'b1,1'b1,1'b1,8'h09, 8'hDE,8'h09,1'b0,1'b0,16'h0000, 4'd7 },  // R7 tx en + break
        '{1'b1,1'b1,1'b1,1'b1,8'h35, 8'hDE,8'h25,1'b1,1'b0,16'h0000, 4'd8 },  // R8 err clear, R5
        '{1'b1,1'b0,1'b0,1'b0,8'h00, 8'hDE,8'h25,1'b0,1'b0,16'h0000, 4'd8 },  // R8 not held
        '{1'b1,1'b1,1'b1,1'b1,8'h50, 8'h00,8'h00,1'b1,1'b1,16'h0000, 4'd4 },  // R4 + R8 together
        '{1'b1,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h00,1'b0,1'b0,16'h0000, 4'd4 },  // R4 pulse ends
        '{1'b1,1'b1,1'b1,1'b1,8'h0C, 8'h0C,8'h00,1'b0,1'b0,16'h0000, 4'd6 },  // R6 sync, two chars
        '{1'b1,1'b1,1'b1,1'b1,8'h40, 8'h0C,8'h00,1'b0,1'b0,16'h0040, 4'd6 },  // R6 bit6 no reset
        '{1'b1,1'b1,1'b1,1'b1,8'h16, 8'h0C,8'h00,1'b0,1'b0,16'h1640, 4'd6 },  // R6 second sync
        '{1'b1,1'b1,1'b1,1'b1,8'h11, 8'h0C,8'h01,1'b1,1'b0,16'h1640, 4'd6 },  // R6 then command
        '{1'b1,1'b1,1'b1,1'b1,8'h40, 8'h00,8'h00,1'b0,1'b1,16'h0000, 4'd4 },  // R4 clears sync
        '{1'b1,1'b1,1'b1,1'b1,8'h8C, 8'h8C,8'h00,1'b0,1'b0,16'h0000, 4'd6 },  // R6 single sync
        '{1'b1,1'b1,1'b1,1'b1,8'h96, 8'h8C,8'h00,1'b0,1'b0,16'h0096, 4'd6 },  // R6 one sync
        '{1'b1,1'b1,1'b1,1'b1,8'h05, 8'h8C,8'h05,1'b0,1'b0,16'h0096, 4'd6 },  // R6 command next
        '{1'b0,1'b1,1'b1,1'b1,8'h01, 8'h00,8'h00,1'b0,1'b0,16'h0000, 4'd10},  // R10 reset wins
        '{1'b1,1'b1,1'b1,1'b1,8'h4D, 8'h4D,8'h00,1'b0,1'b0,16'h0000, 4'd9 },  // R9 decode 1x
        '{1'b1,1'b1,1'b1,1'b1,8'hAA, 8'h4D,8'hAA,1'b0,1'b0,16'h0000, 4'd5 },  // R5 mode locked
        '{1'b1,1'b1,1'b1,1'b0,8'hFF, 8'h4D,8'hAA,1'b0,1'b0,16'h0000, 4'd2 }   // R2 no strobe
    };

    task automatic drive(input logic rn, input logic s, input logic c,
                         input logic w, input logic [7:0] d);
        @(negedge clk);
        rst_n = rn; bus_sel = s; bus_ctl = c; bus_wr = w; bus_din = d;
        @(posedge clk);
        #2;
        bus_wr = 1'b0;
    endtask

    // Expected fields are decoded from the raw mode byte per R9.
    task automatic check(input int req, input logic [7:0] em,
                         input logic [7:0] ec, input logic ee,
                         input logic es, input logic [15:0] esy);
        logic [31:0] act, exp;
        act = {baud_sel, char_bits, parity_en, parity_even, stop_code,
               sync_single, cmd_word, tx_enable, send_break, err_clear,
               soft_reset, 1'b0, 6'd0};
        exp = {em[1:0], 4'(5 + em[3:2]), em[4], em[5], em[7:6], em[7],
               ec, ec[0], ec[3], ee, es, 1'b0, 6'd0};
        n_checks++;
        if (act !== exp || sync_chars !== esy) begin
            n_fail++;
            $display("FAIL R%0d: actual %h/%h expected %h/%h",
                     req, act, sync_chars, exp, esy);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_ctl = 1'b0; bus_wr = 1'b0; bus_din = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        check(1, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000);       // R1 reset state
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VT[i].rn, VT[i].sel, VT[i].ctl, VT[i].wr, VT[i].din);
            check(int'(VT[i].req), VT[i].em, VT[i].ec, VT[i].ee, VT[i].es, VT[i].esy);
        end

        // R4: internal reset then a mode word in the pulse cycle itself
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h40);
        check(4, 8'h00, 8'h00, 1'b0, 1'b1, 16'h0000);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h02);
        check(4, 8'h02, 8'h00, 1'b0, 1'b0, 16'h0000);

        // R8: back-to-back error clears, then released
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h10);
        check(8, 8'h02, 8'h00, 1'b1, 1'b0, 16'h0000);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h11);
        check(8, 8'h02, 8'h01, 1'b1, 1'b0, 16'h0000);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check(8, 8'h02, 8'h01, 1'b0, 1'b0, 16'h0000);

        // R1: external reset from command phase, then first write is mode
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        check(1, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h3F);
        check(9, 8'h3F, 8'h00, 1'b0, 1'b0, 16'h0000);        // R9 64x, 8 bits

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule